// File: doc/BRIEF.md
# Converter Power-State Arbiter

This block decides whether the conversion circuitry of a data converter is powered. Two sources can request power-down: an external pin level, and decoded software instructions that arrive as one-cycle power-up and power-down pulses. The two sources are not simply ORed together.

A high pin always forces power-down. A software power-down takes effect whatever the pin is doing. Once software has powered the block down, it comes back up in one of two ways: a software power-up issued while the pin is low, or a full high-then-low pulse on the pin. A software power-up issued while the pin is high is dropped.

The digital I/O side stays enabled in every state. A power-down that arrives while a conversion is busy aborts that conversion. The block then raises a flag that marks results as unreliable. The flag is cleared by the first conversion that both starts and finishes while the block is powered up.

Top module: `pd_arbiter`

## Requirements
- R1: After reset, `analog_en_o` is 1, `result_invalid_o` is 0 and the software-down state is clear.
- R2: The pin passes through a two-flop synchronizer. Two cycles after `pd_pin_i` has been high on consecutive sampled edges, `analog_en_o` is 0 for as long as the synchronized pin stays high.
- R3: A `sw_up_i` pulse seen while the synchronized pin is high is ignored. The block stays powered down, and the pulse does not clear a software-down state.
- R4: A `sw_down_i` pulse sets the software-down state. `analog_en_o` is 0 in the next cycle.
- R5: A `sw_up_i` pulse without `sw_down_i`, seen while the synchronized pin is low, clears the software-down state. `analog_en_o` is 1 in the next cycle unless the synchronized pin has risen.
- R6: While the software-down state is set, a synchronized pin rise followed by a fall clears that state. `analog_en_o` returns to 1 three cycles after the raw pin falls.
- R7: A pin rise that happened before the software-down state was set does not clear that state when the pin falls.
- R8: When `sw_up_i` and `sw_down_i` are high in the same cycle, power-down wins.
- R9: `dio_en_o` is 1 in every cycle, in every power state.
- R10: If `conv_busy_i` is high in a cycle where `analog_en_o` is 0, `result_invalid_o` is 1 in the next cycle.
- R11: `result_invalid_o` clears one cycle after the falling edge of `conv_busy_i`, but only if that conversion rose and fell while `analog_en_o` stayed 1. A conversion that was running during power-down does not clear it.
- R12: `result_invalid_o` rises only in the cycle after `conv_busy_i` was high while powered down. Conversions that run entirely while powered up leave it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_pin_i | input | 1 | Raw power-down pin level, high requests power-down |
| sw_up_i | input | 1 | One-cycle decoded software power-up command |
| sw_down_i | input | 1 | One-cycle decoded software power-down command |
| conv_busy_i | input | 1 | High while the conversion engine is converting |
| analog_en_o | output | 1 | High when the conversion circuitry is powered |
| result_invalid_o | output | 1 | High while the next result is unreliable |
| dio_en_o | output | 1 | Digital I/O enable, always high |

## Verification
The assertions check the single-cycle rules on every cycle:
- a held-high pin forces power-down;
- a software power-down takes effect in the next cycle;
- a software power-up while the pin is low takes effect in the next cycle;
- the I/O enable never drops;
- the invalid flag is raised by, and only by, a busy conversion during power-down.

Some behaviours depend on a history of several events, so only the directed scenarios can show them. These are recovery through a high-then-low pin pulse, the refusal to recover from a pin rise that came before the software power-down, and the rule that an aborted conversion does not clear the invalid flag.

// File: rtl/pd_arbiter.sv
module pd_arbiter (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_pin_i,
  input  logic sw_up_i,
  input  logic sw_down_i,
  input  logic conv_busy_i,
  output logic analog_en_o,
  output logic result_invalid_o,
  output logic dio_en_o
);

  logic pin_m, pin_s, pin_d;
  logic sw_dn_q, armed_q;
  logic busy_d, conv_ok_q, inv_q;

  wire pin_rise  = pin_s & ~pin_d;
  wire pin_fall  = ~pin_s & pin_d;
  wire up_ok     = sw_up_i & ~sw_down_i & ~pin_s;
  wire pulse_rec = pin_fall & armed_q;
  wire busy_rise = conv_busy_i & ~busy_d;
  wire busy_fall = ~conv_busy_i & busy_d;

  assign analog_en_o      = ~pin_s & ~sw_dn_q;
  assign result_invalid_o = inv_q;
  assign dio_en_o         = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_m <= 1'b0;
      pin_s <= 1'b0;
      pin_d <= 1'b0;
    end else begin
      pin_m <= pd_pin_i;
      pin_s <= pin_m;
      pin_d <= pin_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_dn_q <= 1'b0;
      armed_q <= 1'b0;
    end else if (sw_down_i) begin
      sw_dn_q <= 1'b1;
      armed_q <= 1'b0;
    end else if (up_ok || pulse_rec) begin
      sw_dn_q <= 1'b0;
      armed_q <= 1'b0;
    end else if (sw_dn_q && pin_rise) begin
      armed_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_d    <= 1'b0;
      conv_ok_q <= 1'b0;
      inv_q     <= 1'b0;
    end else begin
      busy_d <= conv_busy_i;
      if (!analog_en_o)   conv_ok_q <= 1'b0;
      else if (busy_rise) conv_ok_q <= 1'b1;
      else if (busy_fall) conv_ok_q <= 1'b0;
      if (conv_busy_i && !analog_en_o)
        inv_q <= 1'b1;
      else if (busy_fall && conv_ok_q && analog_en_o)
        inv_q <= 1'b0;
    end
  end

endmodule

// File: rtl/pd_arbiter_chk.sv
module pd_arbiter_chk (
  input logic clk,
  input logic rst_n,
  input logic pd_pin_i,
  input logic pin_s,
  input logic sw_up_i,
  input logic sw_down_i,
  input logic conv_busy_i,
  input logic analog_en_o,
  input logic result_invalid_o,
  input logic dio_en_o
);

  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  a_r2_pin_forces_down: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && $past(pd_pin_i) && $past(pd_pin_i, 2)) |-> !analog_en_o);

  a_r4_sw_down_next: assert property (@(posedge clk) disable iff (!rst_n)
    sw_down_i |=> !analog_en_o);

  a_r5_sw_up_next: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_up_i && !sw_down_i && !pin_s) |=> (analog_en_o || pin_s));

  a_r9_dio_always_on: assert property (@(posedge clk) disable iff (!rst_n)
    dio_en_o);

  a_r10_abort_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_busy_i && !analog_en_o) |=> result_invalid_o);

  a_r12_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 2'd0 && $rose(result_invalid_o)) |-> $past(conv_busy_i && !analog_en_o));

endmodule

bind pd_arbiter pd_arbiter_chk i_chk (
  .clk(clk), .rst_n(rst_n), .pd_pin_i(pd_pin_i), .pin_s(pin_s),
  .sw_up_i(sw_up_i), .sw_down_i(sw_down_i), .conv_busy_i(conv_busy_i),
  .analog_en_o(analog_en_o), .result_invalid_o(result_invalid_o),
  .dio_en_o(dio_en_o)
);

// File: tb/test_pd_arbiter.sv
module test_pd_arbiter;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pd_pin = 1'b0, sw_up = 1'b0, sw_down = 1'b0, busy = 1'b0;
  logic analog_en, invalid, dio_en;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pd_arbiter i_pd_arbiter (
    .clk(clk), .rst_n(rst_n), .pd_pin_i(pd_pin), .sw_up_i(sw_up),
    .sw_down_i(sw_down), .conv_busy_i(busy), .analog_en_o(analog_en),
    .result_invalid_o(invalid), .dio_en_o(dio_en)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", what, act, exp);
    end
  endtask

  task automatic pulse(input logic up, input logic dn);
    sw_up = up; sw_down = dn;
    tick(1);
    sw_up = 1'b0; sw_down = 1'b0;
  endtask

  task automatic t_reset;
    check(analog_en, 1'b1, "R1 analog_en after reset");
    check(invalid, 1'b0, "R1 invalid after reset");
    check(dio_en, 1'b1, "R1/R9 dio_en after reset");
  endtask

  task automatic t_pin_down;
    pd_pin = 1'b1;
    tick(1);
    check(analog_en, 1'b1, "R2 one cycle into synchronizer");
    tick(1);
    check(analog_en, 1'b0, "R2 pin high powers down");
    pulse(1'b1, 1'b0);
    check(analog_en, 1'b0, "R3 sw_up ignored while pin high");
    check(dio_en, 1'b1, "R9 dio_en while pin down");
    pd_pin = 1'b0;
    tick(4);
    check(analog_en, 1'b1, "R2 pin low powers up");
  endtask

  task automatic t_sw_down_up;
    pulse(1'b0, 1'b1);
    check(analog_en, 1'b0, "R4 sw_down next cycle");
    tick(3);
    check(analog_en, 1'b0, "R4 sw_down held");
    check(dio_en, 1'b1, "R9 dio_en while sw down");
    pulse(1'b1, 1'b0);
    check(analog_en, 1'b1, "R5 sw_up next cycle");
  endtask

  task automatic t_pin_recover;
    pulse(1'b0, 1'b1);
    pd_pin = 1'b1;
    tick(4);
    check(analog_en, 1'b0, "R6 down while pin high");
    pd_pin = 1'b0;
    tick(2);
    check(analog_en, 1'b0, "R6 still down before fall seen");
    tick(1);
    check(analog_en, 1'b1, "R6 pin pulse recovers");
  endtask

  task automatic t_no_arm;
    pd_pin = 1'b1;
    tick(4);
    pulse(1'b0, 1'b1);
    tick(1);
    pulse(1'b1, 1'b0);
    pd_pin = 1'b0;
    tick(4);
    check(analog_en, 1'b0, "R7 earlier rise does not recover");
    check(analog_en, 1'b0, "R3 sw_up during pin high did not clear latch");
    pulse(1'b1, 1'b0);
    check(analog_en, 1'b1, "R5 sw_up recovers after R7 case");
  endtask

  task automatic t_both;
    pulse(1'b1, 1'b1);
    check(analog_en, 1'b0, "R8 down wins over up");
    tick(2);
    check(analog_en, 1'b0, "R8 stays down");
    pulse(1'b1, 1'b0);
    check(analog_en, 1'b1, "R8 later sw_up recovers");
  endtask

  task automatic t_invalid;
    busy = 1'b1; tick(3); busy = 1'b0; tick(2);
    check(invalid, 1'b0, "R12 clean conversion keeps flag low");
    busy = 1'b1; tick(2);
    pulse(1'b0, 1'b1);
    tick(1);
    check(invalid, 1'b1, "R10 power-down during busy flags");
    pulse(1'b1, 1'b0);
    tick(1);
    busy = 1'b0; tick(2);
    check(invalid, 1'b1, "R11 aborted conversion does not clear");
    busy = 1'b1; tick(3); busy = 1'b0;
    tick(1);
    check(invalid, 1'b0, "R11 clean conversion clears flag");
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_pin_down();
    t_sw_down_up();
    t_pin_recover();
    t_no_arm();
    t_both();
    t_invalid();
    check(dio_en, 1'b1, "R9 dio_en at end");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule